// File: doc/BRIEF.md
# 8086 Bus Demultiplexer and Address Decoder

This block sits between a minimum-mode 8086 and the memory and peripherals around it. When the address-latch strobe is sampled high on a clock edge, the block captures the sixteen multiplexed address/data lines, the four upper address lines, the byte-high-enable line and the memory/I-O status line. It holds all of them until the next strobe, because the processor reuses the low lines for data and floats the upper lines and byte-high-enable later in the cycle. No external transparent latches are needed.

The latched address drives the selects. A memory cycle goes to SRAM or to the boot ROM according to address bit 19 alone. SRAM fills the lower 512 KB, and ROM fills the upper half, which holds the reset vector. Both memories are 16 bits wide and have low and high byte-lane enables. An I/O cycle is decoded on all sixteen port bits. It goes to one of four UART channels, an SPI controller or a local register file. A read from a port that no target claims is answered by the block, which drives all ones.

Top module: `bus_glue`

## Requirements
- R1: On a rising clock edge with `ale` high, `addr[15:0]` takes the value of `ad`, and this is visible from that edge onward. After reset `addr` is zero.
- R2: On the same edge, `addr[19:16]` takes `aHigh`, and the byte-high-enable and memory/I-O status are captured. All captured values stay unchanged while `ale` is low, whatever the pins do.
- R3: A memory cycle is one whose status was captured as `memNotIo`=1. In a memory cycle with a strobe active, `ramSel` is high when latched bit 19 is 0, and `romSel` is high when it is 1.
- R4: In a memory cycle with a strobe active, `laneLo` is high when latched bit 0 is 0, and `laneHi` is high when the captured byte-high-enable was 0. Outside that condition both lanes are low.
- R5: In an I/O cycle with a strobe active, `uartSel[k]` is high exactly when the latched port lies in 0x80+8k to 0x87+8k, for k = 0 to 3.
- R6: In an I/O cycle with a strobe active, `spiSel` is high for ports 0xA0 to 0xA7, and `regSel` is high for ports 0xC0 to 0xCF. The upper port bits must be zero for any hit.
- R7: No select and no lane is high unless `rdN` or `wrN` is low. Strobes seen before the first captured address after reset select nothing.
- R8: For an I/O read (`rdN` low) of a port that no target claims, `idleRdEn` is high and `idleRdData` is 0xFFFF. Otherwise `idleRdEn` is low and `idleRdData` is 0. Writes to unclaimed ports raise nothing.
- R9: At most one of `romSel`, `ramSel`, `uartSel`, `spiSel`, `regSel` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ale | input | 1 | Address-latch strobe from the processor |
| memNotIo | input | 1 | Status: 1 for memory cycle, 0 for I/O cycle |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| bheN | input | 1 | Byte-high-enable, active low |
| aHigh | input | 4 | Upper address lines 19..16 |
| ad | input | 16 | Multiplexed address/data lines |
| addr | output | 20 | Latched address |
| romSel | output | 1 | Boot ROM select |
| ramSel | output | 1 | SRAM select |
| laneLo | output | 1 | Low byte-lane enable for memory |
| laneHi | output | 1 | High byte-lane enable for memory |
| uartSel | output | 4 | Per-channel UART select |
| spiSel | output | 1 | SPI controller select |
| regSel | output | 1 | Local register file select |
| idleRdEn | output | 1 | Block drives read data for an unclaimed port |
| idleRdData | output | 16 | Read data for an unclaimed port |

## Verification
Captured address and status appear one register stage after the edge on which `ale` is sampled high. Selects, lanes and the unclaimed-port response are combinational in the read and write strobes, so they follow a strobe change in the same cycle. The bench drives inputs a quarter period after each rising edge. Its reference model updates its latched state on the rising edge, and every output is compared with that model on each falling edge, after both the register update and the combinational settling.

// File: rtl/bus_glue_pkg.sv
package bus_glue_pkg;
  // strobes from control to the address datapath
  typedef struct packed {
    logic capture;   // take a new address this edge
    logic access;    // a strobe is active on a captured cycle
    logic reading;   // read strobe active on a captured cycle
  } strobe_t;
endpackage

// File: rtl/bus_ctrl.sv
module bus_ctrl
  import bus_glue_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ale,
  input  logic          rdN,
  input  logic          wrN,
  input  logic          memLatch,
  input  logic [AW-1:0] addr,
  output strobe_t       strb,
  output logic          romSel,
  output logic          ramSel
);
  logic cycleValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)    cycleValid <= 1'b0;
    else if (ale) cycleValid <= 1'b1;
  end

  always_comb begin
    strb.capture = ale;
    strb.access  = cycleValid & (~rdN | ~wrN);
    strb.reading = cycleValid & ~rdN;
  end

  // memory space split on the top address bit only
  assign ramSel = strb.access & memLatch & ~addr[AW-1];
  assign romSel = strb.access & memLatch &  addr[AW-1];

  p_mem_exclusive_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(romSel && ramSel));
  p_no_sel_before_ale_r7: assert property (@(posedge clk) disable iff (!rstN)
    !cycleValid |-> !(romSel || ramSel));
endmodule

// File: rtl/bus_latch.sv
module bus_latch
  import bus_glue_pkg::*;
#(
  parameter int DW = 16,
  parameter int HW = 4,
  localparam int AW = DW + HW
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strb,
  input  logic [DW-1:0] ad,
  input  logic [HW-1:0] aHigh,
  input  logic          bheN,
  input  logic          memNotIo,
  output logic [AW-1:0] addr,
  output logic          memLatch,
  output logic          laneLo,
  output logic          laneHi
);
  logic bheLatchN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr      <= '0;
      bheLatchN <= 1'b1;
      memLatch  <= 1'b0;
    end else if (strb.capture) begin
      addr      <= {aHigh, ad};
      bheLatchN <= bheN;
      memLatch  <= memNotIo;
    end
  end

  assign laneLo = strb.access & memLatch & ~addr[0];
  assign laneHi = strb.access & memLatch & ~bheLatchN;

  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(addr) && $stable(memLatch));
  p_addr_take_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> addr[DW-1:0] == $past(ad));
endmodule

// File: rtl/io_decode.sv
module io_decode #(
  parameter int PW          = 16,
  parameter int UART_COUNT  = 4,
  parameter int UART_BASE   = 'h80,
  parameter int UART_WIN_LG = 3,
  parameter int SPI_BASE    = 'hA0,
  parameter int SPI_WIN_LG  = 3,
  parameter int REG_BASE    = 'hC0,
  parameter int REG_WIN_LG  = 4
) (
  input  logic [PW-1:0]         port,
  input  logic                  enable,
  output logic [UART_COUNT-1:0] uartSel,
  output logic                  spiSel,
  output logic                  regSel,
  output logic                  anyHit
);
  localparam int UART_STEP = 1 << UART_WIN_LG;
  localparam int SPI_TAG   = SPI_BASE >> SPI_WIN_LG;
  localparam int REG_TAG   = REG_BASE >> REG_WIN_LG;

  for (genvar k = 0; k < UART_COUNT; k++) begin : g_uart
    localparam int CH_TAG = (UART_BASE + k * UART_STEP) >> UART_WIN_LG;
    assign uartSel[k] = enable &&
      (port[PW-1:UART_WIN_LG] == (PW-UART_WIN_LG)'(CH_TAG));
  end

  assign spiSel = enable && (port[PW-1:SPI_WIN_LG] == (PW-SPI_WIN_LG)'(SPI_TAG));
  assign regSel = enable && (port[PW-1:REG_WIN_LG] == (PW-REG_WIN_LG)'(REG_TAG));
  assign anyHit = (|uartSel) | spiSel | regSel;

  always_comb begin
    if (!enable) p_io_quiet_r5: assert (anyHit == 1'b0);
  end
endmodule

// File: rtl/bus_glue.sv
module bus_glue
  import bus_glue_pkg::*;
#(
  parameter int DW         = 16,
  parameter int HW         = 4,
  parameter int UART_COUNT = 4,
  localparam int AW = DW + HW
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  ale,
  input  logic                  memNotIo,
  input  logic                  rdN,
  input  logic                  wrN,
  input  logic                  bheN,
  input  logic [HW-1:0]         aHigh,
  input  logic [DW-1:0]         ad,
  output logic [AW-1:0]         addr,
  output logic                  romSel,
  output logic                  ramSel,
  output logic                  laneLo,
  output logic                  laneHi,
  output logic [UART_COUNT-1:0] uartSel,
  output logic                  spiSel,
  output logic                  regSel,
  output logic                  idleRdEn,
  output logic [DW-1:0]         idleRdData
);
  strobe_t strb;
  logic    memLatch;
  logic    anyHit;

  bus_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .ale(ale), .rdN(rdN), .wrN(wrN),
    .memLatch(memLatch), .addr(addr), .strb(strb),
    .romSel(romSel), .ramSel(ramSel)
  );

  bus_latch #(.DW(DW), .HW(HW)) u_latch (
    .clk(clk), .rstN(rstN), .strb(strb), .ad(ad), .aHigh(aHigh),
    .bheN(bheN), .memNotIo(memNotIo), .addr(addr), .memLatch(memLatch),
    .laneLo(laneLo), .laneHi(laneHi)
  );

  io_decode #(.PW(DW), .UART_COUNT(UART_COUNT)) u_io (
    .port(addr[DW-1:0]), .enable(strb.access & ~memLatch),
    .uartSel(uartSel), .spiSel(spiSel), .regSel(regSel), .anyHit(anyHit)
  );

  assign idleRdEn   = strb.reading & ~memLatch & ~anyHit;
  assign idleRdData = idleRdEn ? '1 : '0;

  p_one_target_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({romSel, ramSel, uartSel, spiSel, regSel}));
  p_sel_needs_strobe_r7: assert property (@(posedge clk) disable iff (!rstN)
    (romSel || ramSel || (|uartSel) || spiSel || regSel || laneLo || laneHi)
      |-> (!rdN || !wrN));
  p_lane_in_mem_r4: assert property (@(posedge clk) disable iff (!rstN)
    (laneLo || laneHi) |-> (romSel || ramSel));
  p_idle_no_target_r8: assert property (@(posedge clk) disable iff (!rstN)
    idleRdEn |-> !(romSel || ramSel || (|uartSel) || spiSel || regSel) && !rdN);
endmodule

// File: tb/sim_bus_glue.sv
module sim_bus_glue;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ale = 1'b0, memNotIo = 1'b0, rdN = 1'b1, wrN = 1'b1, bheN = 1'b1;
  logic [3:0]  aHigh = '0;
  logic [15:0] ad = '0;
  logic [19:0] addr;
  logic romSel, ramSel, laneLo, laneHi, spiSel, regSel, idleRdEn;
  logic [3:0]  uartSel;
  logic [15:0] idleRdData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  bus_glue u0 (.*);

  // behavioural reference state
  int refA = 0;
  bit refBhe = 1, refMem = 0, refValid = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refA = 0; refBhe = 1; refMem = 0; refValid = 0;
    end else if (ale) begin
      refA = {aHigh, ad}; refBhe = bheN; refMem = memNotIo; refValid = 1;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      bit acc, io, hit;
      int p;
      acc = refValid && (!rdN || !wrN);
      io  = acc && !refMem;
      p   = refA & 'hFFFF;
      hit = 0;
      chk("R1 addr", int'(addr), refA);
      chk("R3 ram", ramSel, acc && refMem && ((refA >> 19) == 0));
      chk("R3 rom", romSel, acc && refMem && ((refA >> 19) == 1));
      chk("R4 lanelo", laneLo, acc && refMem && (refA % 2 == 0));
      chk("R4 lanehi", laneHi, acc && refMem && !refBhe);
      for (int k = 0; k < 4; k++) begin
        bit e;
        e = io && p >= 'h80 + 8*k && p <= 'h87 + 8*k;
        hit |= e;
        chk($sformatf("R5 uart%0d", k), uartSel[k], e);
      end
      chk("R6 spi", spiSel, io && p >= 'hA0 && p <= 'hA7);
      chk("R6 reg", regSel, io && p >= 'hC0 && p <= 'hCF);
      hit |= (p >= 'hA0 && p <= 'hA7) || (p >= 'hC0 && p <= 'hCF);
      chk("R8 idle en", idleRdEn, io && !rdN && !hit);
      chk("R8 idle data", int'(idleRdData), (io && !rdN && !hit) ? 'hFFFF : 0);
      chk("R9 one target",
          int'(romSel) + ramSel + spiSel + regSel + $countones(uartSel) <= 1, 1);
    end
  end

  task automatic drv_gap();
    @(posedge clk); #5;
  endtask

  // one bus cycle: address phase, then pins change while the strobe is held
  task automatic busCycle(bit mem, int a, bit bhe, bit rd, bit wr);
    drv_gap();
    ale = 1; memNotIo = mem; aHigh = 4'(a >> 16); ad = 16'(a); bheN = bhe;
    drv_gap();
    ale = 0; ad = 16'hA5C3; aHigh = 4'hF; bheN = ~bhe; memNotIo = ~mem;  // R2 hold
    rdN = !rd; wrN = !wr;
    drv_gap();
    ad = 16'h3C5A; aHigh = 4'h0;
    drv_gap();
    rdN = 1; wrN = 1;
  endtask

  initial begin
    repeat (3) drv_gap();
    rstN = 1;
    // R7: strobes before any captured address
    drv_gap(); rdN = 0; memNotIo = 1;
    drv_gap(); rdN = 1; wrN = 0;
    drv_gap(); wrN = 1;
    // R3/R4 memory cycles
    busCycle(1, 'h00000, 0, 1, 0);   // even word in RAM
    busCycle(1, 'h7FFFF, 0, 1, 0);   // odd high byte, top of RAM
    busCycle(1, 'h80000, 1, 0, 1);   // even low byte, bottom of ROM
    busCycle(1, 'hFFFF0, 0, 1, 0);   // reset vector
    busCycle(1, 'h12345, 1, 0, 1);
    // R5/R6/R8 I/O sweep, edges of every window included
    for (int p = 'h78; p <= 'hD8; p += 1) busCycle(0, p, 1, 1, 0);
    busCycle(0, 'h1080, 1, 1, 0);    // upper port bits set: unclaimed
    busCycle(0, 'h00F0, 1, 0, 1);    // unclaimed write
    busCycle(0, 'hFFFF, 0, 1, 0);
    busCycle(0, 'h00A3, 1, 0, 1);
    // mid-cycle reset returns to idle
    drv_gap(); ale = 1; memNotIo = 1; ad = 16'h0042; aHigh = 0;
    drv_gap(); ale = 0; rstN = 0;
    drv_gap(); rdN = 0;
    drv_gap(); rstN = 1;
    drv_gap(); rdN = 1;
    repeat (2) drv_gap();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule